// File: doc/BRIEF.md
# Critical-Conduction Boost Gate Sequencer

This block produces the switch gate for a boost power stage that runs at the boundary between continuous and discontinuous inductor current. It works from digitized events: a sampled voltage code from the auxiliary winding's zero-current sense, a digital over-current flag, an enable, and a control word that stands in for the loop compensator output. A new switching period starts when the sensed winding voltage falls through a hysteretic threshold pair. Such an edge means the inductor current has reached zero. The gate then turns on after a short fixed delay.

An internal sawtooth counter sets the on-time. It restarts from zero at each turn-on, and the gate drops when the count reaches the control word. The control word is clamped to a ceiling, and a word under a floor suppresses switching altogether. A blanking window measured from each gate rise rejects early zero-current edges, which caps the switching frequency. A watchdog on the off-time forces a turn-on when no qualifying edge arrives, and this is also how switching begins after enable. Two one-cycle status pulses report a forced restart and a rejected early edge. All intervals are parameters in clock cycles. The pins are plain control and status signals; no streaming handshake is involved.

Top module: `crm_gate_seq`

## Requirements
- R1: The internal detect flag sets only when `zcd_code` is strictly above `ZCD_HI`, clears only when it is strictly below `ZCD_LO`, and otherwise holds. A switching start is triggered only by the flag clearing.
- R2: A qualifying falling edge seen at clock edge E makes `gate` high from clock edge E+`DLY_CYC` onward.
- R3: A falling edge evaluated fewer than `BLANK_CYC` clock edges after the last gate rise does not start a pulse. It raises `zcd_ignored` for one cycle, and the sequencer keeps waiting for a later edge.
- R4: If the sequencer has been off for `RESTART_CYC` clock edges with no qualifying edge, it starts a pulse and raises `restart_pulse` for one cycle. After enable rises, the gate therefore first goes high `RESTART_CYC`+`DLY_CYC` cycles later.
- R5: With no over-current condition, `gate` stays high for exactly the effective control value in clock cycles.
- R6: The effective control value is `ctrl_word` clamped to `CTRL_MAX`, which bounds the on-time.
- R7: When a start is requested while the effective control value is below `CTRL_MIN`, no pulse is issued and no status pulse is raised.
- R8: `ocp` sampled high while `gate` is high makes `gate` low after the next clock edge.
- R9: While `en` is low, `gate` is low after the next edge, all timers clear, and the detect flag is reset.
- R10: Falling edges that occur during the turn-on delay or the on-time are ignored. They neither lengthen the pulse nor start a new one, and they raise no status pulse.
- R11: When a qualifying edge and the restart timeout land on the same clock edge, the edge wins. One pulse is started, and `restart_pulse` stays low.
- R12: Out of reset, `gate`, `restart_pulse` and `zcd_ignored` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low holds the gate off and clears state |
| zcd_code | input | ZCD_W | Sampled auxiliary-winding voltage code |
| ocp | input | 1 | Over-current flag, high ends the on-time |
| ctrl_word | input | CTRL_W | On-time demand in sawtooth counts |
| gate | output | 1 | Switch gate command |
| restart_pulse | output | 1 | One-cycle pulse on a watchdog-forced start |
| zcd_ignored | output | 1 | One-cycle pulse on a blanked early edge |

## Verification
The restart watchdog and a qualifying falling edge can both request a start on the same clock edge. The bench provokes this by counting cycles from enable and placing the code drop so that the edge is evaluated at exactly the timeout edge. It then judges the outcome in two ways: the gate must rise at the normal delay after that edge, and `restart_pulse` must stay low throughout. An over-current flag that coincides with the natural end of the on-time is the other overlap, and the pulse must still end after that edge.

// File: rtl/crm_pkg.sv
package crm_pkg;
  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_DLY = 2'd1,
    ST_ON  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/crm_zcd_qual.sv
module crm_zcd_qual #(
  parameter int ZCD_W  = 8,
  parameter int ZCD_HI = 150,
  parameter int ZCD_LO = 140
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ZCD_W-1:0] code,
  output logic             fall_evt
);
  logic det_flag;
  logic above_hi, below_lo;

  assign above_hi = code > ZCD_W'(ZCD_HI);
  assign below_lo = code < ZCD_W'(ZCD_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        det_flag <= 1'b0;
    else if (!en)      det_flag <= 1'b0;
    else if (above_hi) det_flag <= 1'b1;
    else if (below_lo) det_flag <= 1'b0;
  end

  // a falling edge is the cycle in which a set flag is about to clear
  assign fall_evt = en & det_flag & below_lo;

  assert_flag_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_flag) |-> $past(code) > ZCD_W'(ZCD_HI));
  assert_flag_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(det_flag) |-> ($past(code) < ZCD_W'(ZCD_LO) || !$past(en)));
endmodule

// File: rtl/crm_sat_timer.sv
module crm_sat_timer #(
  parameter int LIMIT     = 15,
  parameter bit RESET_SAT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic preset,
  output logic done
);
  localparam int W = $clog2(LIMIT + 2);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= RESET_SAT ? W'(LIMIT) : '0;
    else if (preset)              cnt <= W'(LIMIT);
    else if (clear)               cnt <= '0;
    else if (cnt != W'(LIMIT))    cnt <= cnt + W'(1);
  end

  assign done = (cnt == W'(LIMIT));
endmodule

// File: rtl/crm_ontime.sv
module crm_ontime #(
  parameter int CTRL_W   = 12,
  parameter int CTRL_MAX = 650,
  parameter int CTRL_MIN = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CTRL_W-1:0] ctrl_word,
  output logic              ctrl_ok,
  output logic              expire
);
  localparam int SAW_W = $clog2(CTRL_MAX + 2);
  localparam int CMP_W = (SAW_W + 1 > CTRL_W) ? SAW_W + 1 : CTRL_W;

  logic [SAW_W-1:0]  saw;
  logic [SAW_W:0]    saw_inc;
  logic [CTRL_W-1:0] ctrl_eff;

  assign ctrl_eff = (ctrl_word > CTRL_W'(CTRL_MAX)) ? CTRL_W'(CTRL_MAX) : ctrl_word;
  assign ctrl_ok  = ctrl_eff >= CTRL_W'(CTRL_MIN);
  assign saw_inc  = (SAW_W + 1)'(saw) + (SAW_W + 1)'(1);
  assign expire   = CMP_W'(saw_inc) >= CMP_W'(ctrl_eff);

  // sawtooth sits at zero outside the on-time and ramps one count per cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        saw <= '0;
    else if (!run)                     saw <= '0;
    else if (saw != SAW_W'(CTRL_MAX))  saw <= saw + SAW_W'(1);
  end

  assert_saw_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> saw < SAW_W'(CTRL_MAX));
endmodule

// File: rtl/crm_gate_seq.sv
module crm_gate_seq
  import crm_pkg::*;
#(
  parameter int ZCD_W       = 8,
  parameter int ZCD_HI      = 150,
  parameter int ZCD_LO      = 140,
  parameter int CTRL_W      = 12,
  parameter int CTRL_MAX    = 650,
  parameter int CTRL_MIN    = 100,
  parameter int DLY_CYC     = 15,
  parameter int BLANK_CYC   = 330,
  parameter int RESTART_CYC = 15000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ZCD_W-1:0]  zcd_code,
  input  logic              ocp,
  input  logic [CTRL_W-1:0] ctrl_word,
  output logic              gate,
  output logic              restart_pulse,
  output logic              zcd_ignored
);
  seq_st_e st, st_n;
  logic zcd_fall, blank_done, restart_done, dly_done;
  logic ctrl_ok, expire;
  logic edge_ok, start_req, enter_on;

  crm_zcd_qual #(.ZCD_W(ZCD_W), .ZCD_HI(ZCD_HI), .ZCD_LO(ZCD_LO)) u_zcd (
    .clk(clk), .rst_n(rst_n), .en(en), .code(zcd_code), .fall_evt(zcd_fall));

  // cycles since last gate rise; saturated (open) while disabled
  crm_sat_timer #(.LIMIT(BLANK_CYC - 1), .RESET_SAT(1'b1)) u_blank (
    .clk(clk), .rst_n(rst_n), .clear(enter_on), .preset(!en), .done(blank_done));

  // off-time watchdog
  crm_sat_timer #(.LIMIT(RESTART_CYC - 1), .RESET_SAT(1'b0)) u_restart (
    .clk(clk), .rst_n(rst_n), .clear(!en || st != ST_OFF || start_req),
    .preset(1'b0), .done(restart_done));

  // turn-on delay
  crm_sat_timer #(.LIMIT(DLY_CYC - 1), .RESET_SAT(1'b0)) u_dly (
    .clk(clk), .rst_n(rst_n), .clear(st != ST_DLY), .preset(1'b0), .done(dly_done));

  crm_ontime #(.CTRL_W(CTRL_W), .CTRL_MAX(CTRL_MAX), .CTRL_MIN(CTRL_MIN)) u_ontime (
    .clk(clk), .rst_n(rst_n), .run(st == ST_ON), .ctrl_word(ctrl_word),
    .ctrl_ok(ctrl_ok), .expire(expire));

  assign edge_ok   = zcd_fall && blank_done;
  assign start_req = en && (st == ST_OFF) && (edge_ok || restart_done);
  assign enter_on  = en && (st == ST_DLY) && dly_done;

  always_comb begin
    st_n = st;
    if (!en) st_n = ST_OFF;
    else begin
      unique case (st)
        ST_OFF: if (start_req && ctrl_ok) st_n = ST_DLY;
        ST_DLY: if (dly_done)             st_n = ST_ON;
        ST_ON:  if (ocp || expire)        st_n = ST_OFF;
        default:                          st_n = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= ST_OFF;
      restart_pulse <= 1'b0;
      zcd_ignored   <= 1'b0;
    end else begin
      st            <= st_n;
      // an edge in the same cycle takes precedence over the timeout
      restart_pulse <= start_req && ctrl_ok && !edge_ok;
      zcd_ignored   <= en && (st == ST_OFF) && zcd_fall && !blank_done;
    end
  end

  assign gate = (st == ST_ON);

  assert_en_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !gate);
  assert_ocp_cut_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && ocp) |=> !gate);
  assert_rise_after_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> $past(st) == ST_DLY);
  assert_restart_while_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |-> !gate);
  assert_flags_apart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({restart_pulse, zcd_ignored}));
endmodule

// File: tb/crm_gate_seq_tb.sv
module crm_gate_seq_tb;
  localparam int DLY     = 15;
  localparam int BLANK   = 330;
  localparam int RESTART = 15000;
  localparam int CMAX    = 650;
  localparam int CMIN    = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [7:0]  zcd_code = 8'd100;
  logic        ocp = 1'b0;
  logic [11:0] ctrl_word = 12'd300;
  logic        gate, restart_pulse, zcd_ignored;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  crm_gate_seq u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .zcd_code(zcd_code), .ocp(ocp),
    .ctrl_word(ctrl_word), .gate(gate), .restart_pulse(restart_pulse),
    .zcd_ignored(zcd_ignored));

  function automatic int exp_width(input int c);
    int e;
    e = (c > CMAX) ? CMAX : c;
    return (e < CMIN) ? 0 : e;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic zcd_fall_seq(input logic [7:0] low_code);
    zcd_code = 8'd200;
    repeat (3) @(negedge clk);
    zcd_code = low_code;
  endtask

  // negedges until gate seen high (limit returns limit+1)
  task automatic wait_rise(input int limit, output int n);
    n = 0;
    while (n <= limit) begin
      @(negedge clk);
      n++;
      if (gate) break;
    end
  endtask

  task automatic width_meas(output int w);
    w = 1;
    forever begin
      @(negedge clk);
      if (gate) w++; else break;
    end
  endtask

  task automatic quiet(input int n, input string tag);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gate) hits++;
    end
    chk(hits == 0, tag, hits, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, w, seen, c;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(gate == 0 && restart_pulse == 0 && zcd_ignored == 0, "R12 reset outputs",
        {gate, restart_pulse, zcd_ignored}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R4 startup restart
    ctrl_word = 12'd300;
    en = 1'b1;
    n = 0; seen = -1;
    while (n < RESTART + DLY + 5) begin
      @(negedge clk); n++;
      if (restart_pulse) seen = n;
      if (gate) break;
    end
    chk(seen == RESTART, "R4 restart pulse cycle", seen, RESTART);
    chk(n == RESTART + DLY, "R4 first gate after enable", n, RESTART + DLY);
    width_meas(w);
    chk(w == 300, "R5 on-time 300", w, 300);
    repeat (BLANK) @(negedge clk);

    // R2 delay and R5 width, directed
    ctrl_word = 12'd250;
    zcd_fall_seq(8'd100);
    wait_rise(200, n);
    chk(n == DLY + 1, "R2 turn-on delay", n, DLY + 1);
    width_meas(w);
    chk(w == 250, "R5 on-time 250", w, 250);
    repeat (BLANK) @(negedge clk);

    // R1 hysteresis: mid-band does not clear the flag
    zcd_code = 8'd200;
    repeat (3) @(negedge clk);
    zcd_code = 8'd145;
    quiet(40, "R1 mid-band holds flag");
    zcd_code = 8'd139;
    wait_rise(200, n);
    chk(n == DLY + 1, "R1 clear below low threshold", n, DLY + 1);
    width_meas(w);
    repeat (BLANK) @(negedge clk);
    // R1 code equal to high threshold does not set flag
    zcd_code = 8'd150;
    repeat (5) @(negedge clk);
    zcd_code = 8'd100;
    quiet(60, "R1 code at high threshold no set");

    // R6 clamp
    ctrl_word = 12'd4000;
    zcd_fall_seq(8'd100);
    wait_rise(200, n);
    width_meas(w);
    chk(w == CMAX, "R6 clamped on-time", w, CMAX);
    repeat (BLANK) @(negedge clk);

    // R7 below floor / at floor
    ctrl_word = 12'd99;
    zcd_fall_seq(8'd100);
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (gate || restart_pulse || zcd_ignored) seen++;
    end
    chk(seen == 0, "R7 below floor no pulse", seen, 0);
    ctrl_word = 12'd100;
    zcd_fall_seq(8'd100);
    wait_rise(200, n);
    width_meas(w);
    chk(w == 100, "R7 at floor pulse", w, 100);
    repeat (BLANK) @(negedge clk);

    // R3 blanking
    ctrl_word = 12'd110;
    zcd_fall_seq(8'd100);
    wait_rise(200, n);
    width_meas(w);
    zcd_fall_seq(8'd100);
    seen = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (zcd_ignored) seen++;
      if (gate) seen += 100;
    end
    chk(seen == 1, "R3 early edge flagged not started", seen, 1);
    repeat (BLANK) @(negedge clk);
    zcd_fall_seq(8'd100);
    wait_rise(200, n);
    chk(n == DLY + 1, "R3 later edge accepted", n, DLY + 1);
    width_meas(w);
    repeat (BLANK) @(negedge clk);

    // R10 edge during on-time
    ctrl_word = 12'd600;
    zcd_fall_seq(8'd100);
    wait_rise(200, n);
    w = 1; seen = 0;
    forever begin
      @(negedge clk);
      if (zcd_ignored || restart_pulse) seen++;
      if (!gate) break;
      w++;
      if (w == 100) zcd_code = 8'd200;
      if (w == 103) zcd_code = 8'd100;
    end
    chk(w == 600 && seen == 0, "R10 on-time unchanged by edge", w, 600);
    quiet(100, "R10 no new pulse after ignored edge");

    // R8 over-current
    zcd_fall_seq(8'd100);
    wait_rise(200, n);
    repeat (50) @(negedge clk);
    ocp = 1'b1;
    @(negedge clk);
    chk(gate == 0, "R8 ocp ends pulse", gate, 0);
    ocp = 1'b0;
    repeat (BLANK) @(negedge clk);
    // R8 ocp coinciding with natural end
    ctrl_word = 12'd200;
    zcd_fall_seq(8'd100);
    wait_rise(200, n);
    repeat (199) @(negedge clk);
    ocp = 1'b1;
    @(negedge clk);
    chk(gate == 0, "R8 ocp at natural end", gate, 0);
    ocp = 1'b0;
    quiet(BLANK, "R8 stays off after coincident end");

    // random mix (R5 R6 R7)
    for (int k = 0; k < 24; k++) begin
      c = $urandom_range(0, 800);
      ctrl_word = 12'(c);
      zcd_fall_seq(8'(100 + $urandom_range(0, 39)));
      if (exp_width(c) == 0) begin
        quiet(60, "R7 random low control");
      end else begin
        wait_rise(200, n);
        width_meas(w);
        chk(n == DLY + 1 && w == exp_width(c), "R5 random on-time", w, exp_width(c));
        repeat (BLANK + $urandom_range(0, 40)) @(negedge clk);
      end
    end

    // R9 enable low
    ctrl_word = 12'd600;
    zcd_fall_seq(8'd100);
    wait_rise(200, n);
    repeat (20) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(gate == 0, "R9 gate off when disabled", gate, 0);
    zcd_code = 8'd200;
    repeat (5) @(negedge clk);
    en = 1'b1;  // flag remains set only if not reset; drive mid-band first
    zcd_code = 8'd145;
    en = 1'b0;
    repeat (3) @(negedge clk);
    en = 1'b1;
    repeat (3) @(negedge clk);
    zcd_code = 8'd100;
    quiet(100, "R9 detect flag reset by disable");

    // R11 edge coinciding with restart timeout
    en = 1'b0;
    zcd_code = 8'd100;
    repeat (3) @(negedge clk);
    ctrl_word = 12'd300;
    en = 1'b1;
    @(negedge clk);
    zcd_code = 8'd200;
    repeat (RESTART - 2) @(negedge clk);
    zcd_code = 8'd100;
    n = 0; seen = 0;
    while (n <= 200) begin
      @(negedge clk); n++;
      if (restart_pulse) seen++;
      if (gate) break;
    end
    chk(n == DLY + 1, "R11 pulse starts on tie", n, DLY + 1);
    chk(seen == 0, "R11 no restart flag on tie", seen, 0);
    width_meas(w);
    chk(w == 300, "R11 single pulse width", w, 300);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule